// File: doc/BRIEF.md
# Serial Master with DMA Request Lines

This block is a 16-bit synchronous serial master that drives its transfer progress out as DMA request levels. Software or a DMA engine puts a word into the transmit data register. The engine then runs one 16-bit exchange on `sclk`, `mosi` and `miso`. The exchange is clock mode 0 and sends the most significant bit first. The word that comes back is held in a receive register, which sets a receive-full flag. The engine only receives when it sends, so reading a stream of words means writing one dummy word for each word to be read.

Each DMA channel has one request line and two enable bits. One enable bit gates the transmit-buffer-empty condition onto that line. The other gates the receive-full condition. A typical setup gives one channel the transmit enable, so it feeds dummy words, and another channel the receive enable, so it drains the receive register. Reading the receive register clears the full flag, and the receive request falls with it. The slave select pin follows a control bit directly.

Register map on the bus port (addr: content):
- 0: transmit data. Reads return 0.
- 1: receive data.
- 2: control. Bit 0 enables the engine. Bit 1 asserts slave select. Bits 7:4 hold the divider DIV.
- 3: flags. Bit 0 is transmit empty, bit 1 is receive full, bit 2 is overrun and bit 3 is busy.
- 4: transmit request enables, one bit per channel.
- 5: receive request enables, one bit per channel.

Top module: `sdm_top`

## Requirements
- R1: A transfer shifts 16 bits MSB first in mode 0. `sclk` idles low, `miso` is sampled on each rising edge and `mosi` changes on each falling edge. The captured word is then readable at address 1.
- R2: Each `sclk` high phase and each low phase lasts DIV+1 clock cycles, where DIV is taken from control bits 7:4.
- R3: Receive-full (flag bit 1) sets when a transfer completes. A bus read of address 1 clears it.
- R4: No `sclk` activity happens unless a word has been written to address 0 and control bit 0 is 1.
- R5: `ss_n` is the inverse of control bit 1.
- R6: `dma_req[i]` is high while either of these holds: the transmit enable bit i (address 4) is 1 and the transmit buffer is empty (flag bit 0), or the receive enable bit i (address 5) is 1 and receive-full is set. The line is a level and stays high until its condition clears.
- R7: A write to address 0 while the transmit buffer is full is ignored.
- R8: If a transfer completes while receive-full is still set, the overrun flag (bit 2) sets and the new word is discarded. Writing 1 to flag bit 2 clears the overrun flag.
- R9: After reset the flags read 0x0001, `sclk` is 0, `ss_n` is 1 and every `dma_req` line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the clear-on-read of address 1) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, active low |
| dma_req | output | NCH | One DMA request level per channel |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never asserted in the same cycle. They also assume that a strobe addresses only one register, and that `miso` changes only away from rising `sclk` edges. The bench follows these rules. It drives the bus on falling clock edges, with a single strobe held for exactly one cycle. Its slave model moves `miso` only on falling `sclk` edges. It also changes the divider only while the engine is idle, so each measured phase comes from a single DIV value.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int DW = 16;

  typedef enum logic [2:0] {
    A_TXD  = 3'd0,
    A_RXD  = 3'd1,
    A_CTL  = 3'd2,
    A_FLG  = 3'd3,
    A_TXEN = 3'd4,
    A_RXEN = 3'd5
  } sdm_addr_e;

  localparam int CTL_EN  = 0;
  localparam int CTL_SS  = 1;
  localparam int CTL_DIV = 4;
  localparam int FLG_OVR = 2;

  function automatic logic [DW-1:0] pack_flags(input logic tx_empty, input logic rx_full,
                                               input logic ovr, input logic busy);
    pack_flags = {{(DW-4){1'b0}}, busy, ovr, rx_full, tx_empty};
  endfunction

  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] sr, input logic b);
    shift_in = {sr[DW-2:0], b};
  endfunction
endpackage

// File: rtl/sdm_engine.sv
module sdm_engine
  import sdm_pkg::*;
#(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DIVW-1:0] div,
  input  logic            tx_full,
  input  logic [DW-1:0]   tx_buf,
  input  logic            miso,
  output logic            load,
  output logic            done,
  output logic [DW-1:0]   done_word,
  output logic            busy,
  output logic            sclk,
  output logic            mosi
);
  localparam int BW = $clog2(DW);

  logic [DIVW-1:0] cnt;
  logic [BW-1:0]   nfall;
  logic [DW-1:0]   sr;
  logic            samp;
  logic            tick;
  logic            last_fall;

  assign load      = !busy && tx_full && en;
  assign tick      = busy && (cnt == div);
  assign last_fall = tick && sclk && (nfall == BW'(DW-1));
  assign done      = last_fall;
  assign done_word = shift_in(sr, samp);
  assign mosi      = busy ? sr[DW-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sclk  <= 1'b0;
      cnt   <= '0;
      nfall <= '0;
      sr    <= '0;
      samp  <= 1'b0;
    end else if (!busy) begin
      sclk <= 1'b0;
      cnt  <= '0;
      if (load) begin
        busy  <= 1'b1;
        sr    <= tx_buf;
        nfall <= '0;
      end
    end else if (tick) begin
      cnt <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
        samp <= miso;
      end else begin
        sclk  <= 1'b0;
        sr    <= shift_in(sr, samp);
        nfall <= nfall + 1'b1;
        if (last_fall) busy <= 1'b0;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk); // R1
  AST_START_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(tx_full) && $past(en))); // R4
endmodule

// File: rtl/sdm_regs.sv
module sdm_regs
  import sdm_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [2:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            load,
  input  logic            done,
  input  logic [DW-1:0]   done_word,
  input  logic            busy,
  output logic            tx_full,
  output logic [DW-1:0]   tx_buf,
  output logic            rx_full,
  output logic            en,
  output logic            ss_on,
  output logic [DIVW-1:0] div,
  output logic [NCH-1:0]  tx_en,
  output logic [NCH-1:0]  rx_en
);
  logic [DW-1:0] ctl;
  logic [DW-1:0] rx_data;
  logic          ovr;
  logic          wr_tx, rd_rx, clr_ovr;

  assign wr_tx   = bus_wr && (bus_addr == A_TXD);
  assign rd_rx   = bus_rd && (bus_addr == A_RXD);
  assign clr_ovr = bus_wr && (bus_addr == A_FLG) && bus_wdata[FLG_OVR];
  assign en      = ctl[CTL_EN];
  assign ss_on   = ctl[CTL_SS];
  assign div     = ctl[CTL_DIV +: DIVW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      tx_buf  <= '0;
      tx_full <= 1'b0;
      rx_data <= '0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
      tx_en   <= '0;
      rx_en   <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTL)  ctl   <= bus_wdata;
      if (bus_wr && bus_addr == A_TXEN) tx_en <= bus_wdata[NCH-1:0];
      if (bus_wr && bus_addr == A_RXEN) rx_en <= bus_wdata[NCH-1:0];
      if (load) begin
        tx_full <= 1'b0;
      end else if (wr_tx && !tx_full) begin
        tx_buf  <= bus_wdata;
        tx_full <= 1'b1;
      end
      if (clr_ovr) ovr <= 1'b0;
      if (done) begin
        if (rx_full && !rd_rx) begin
          ovr <= 1'b1;
        end else begin
          rx_data <= done_word;
          rx_full <= 1'b1;
        end
      end else if (rd_rx) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_RXD:   bus_rdata = rx_data;
      A_CTL:   bus_rdata = ctl;
      A_FLG:   bus_rdata = pack_flags(!tx_full, rx_full, ovr, busy);
      A_TXEN:  bus_rdata = {{(DW-NCH){1'b0}}, tx_en};
      A_RXEN:  bus_rdata = {{(DW-NCH){1'b0}}, rx_en};
      default: bus_rdata = '0;
    endcase
  end

  AST_RD_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !done) |=> !rx_full); // R3
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_full) |=> (tx_buf == $past(tx_buf))); // R7
  AST_OVR_ON_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_full && !rd_rx) |=> (ovr && rx_data == $past(rx_data))); // R8
endmodule

// File: rtl/sdm_dma_req.sv
module sdm_dma_req #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_empty,
  input  logic           rx_full,
  input  logic [NCH-1:0] tx_en,
  input  logic [NCH-1:0] rx_en,
  output logic [NCH-1:0] dma_req
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign dma_req[g] = (tx_en[g] && tx_empty) || (rx_en[g] && rx_full);
  end

  AST_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && !rx_full) |-> (dma_req == '0)); // R6
endmodule

// File: rtl/sdm_top.sv
module sdm_top
  import sdm_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int DIVW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [2:0]     bus_addr,
  input  logic [15:0]    bus_wdata,
  output logic [15:0]    bus_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic           ss_n,
  output logic [NCH-1:0] dma_req
);
  logic            load, done, busy, tx_full, rx_full, en, ss_on;
  logic [DW-1:0]   done_word, tx_buf;
  logic [DIVW-1:0] div;
  logic [NCH-1:0]  tx_en, rx_en;

  assign ss_n = !ss_on;

  sdm_regs #(.NCH(NCH), .DIVW(DIVW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .load(load), .done(done),
    .done_word(done_word), .busy(busy), .tx_full(tx_full), .tx_buf(tx_buf),
    .rx_full(rx_full), .en(en), .ss_on(ss_on), .div(div), .tx_en(tx_en), .rx_en(rx_en)
  );

  sdm_engine #(.DIVW(DIVW)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div), .tx_full(tx_full), .tx_buf(tx_buf),
    .miso(miso), .load(load), .done(done), .done_word(done_word), .busy(busy),
    .sclk(sclk), .mosi(mosi)
  );

  sdm_dma_req #(.NCH(NCH)) u_req (
    .clk(clk), .rst_n(rst_n), .tx_empty(!tx_full), .rx_full(rx_full),
    .tx_en(tx_en), .rx_en(rx_en), .dma_req(dma_req)
  );

  AST_SS_FOLLOWS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTL) |=> (ss_n == !$past(bus_wdata[CTL_SS]))); // R5
endmodule

// File: tb/sim_sdm_top.sv
module sim_sdm_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic sclk, mosi, miso, ss_n;
  logic [NCH-1:0] dma_req;

  int checks = 0, errors = 0;

  sdm_top #(.NCH(NCH), .DIVW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .dma_req(dma_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model: mode 0, MSB first
  logic [15:0] slave_word = '0;
  int fall_cnt = 0, base = 0, rises = 0, idx;
  logic [15:0] slave_rx = '0;
  assign idx  = fall_cnt - base;
  assign miso = (idx >= 0 && idx < 16) ? slave_word[15 - idx] : 1'b0;
  always @(negedge sclk) fall_cnt <= fall_cnt + 1;
  always @(posedge sclk) begin
    slave_rx <= {slave_rx[14:0], mosi};
    rises    <= rises + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] f;
    for (int n = 0; n < 2000; n++) begin
      rd(3'd3, f);
      if (f[3] == 1'b0 && f[0] == 1'b1) return;
    end
  endtask

  task automatic xfer(input logic [15:0] w, input logic [15:0] s);
    slave_word = s; base = fall_cnt;
    wr(3'd0, w);
    wait_idle();
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, w, s;
    int r0;
    repeat (3) @(negedge clk);
    // R9 reset state
    rd(3'd3, d); check("R9 flags", d, 16'h0001);
    check("R9 sclk", sclk, 0);
    check("R9 ss_n", ss_n, 1);
    check("R9 dma_req", dma_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd3, d); check("R9 flags after release", d, 16'h0001);

    // R5 slave select
    wr(3'd2, 16'h0002); #1 check("R5 ss asserted", ss_n, 0);
    wr(3'd2, 16'h0000); #1 check("R5 ss released", ss_n, 1);

    // R4 enabled but no word written: no clocks
    r0 = rises;
    wr(3'd2, 16'h0001);
    repeat (60) @(negedge clk);
    check("R4 no sclk without word", rises, r0);

    // R1 R2 R3 sweep over divider and data
    for (int dv = 0; dv < 4; dv++) begin
      wr(3'd2, 16'(16'h0003 | (dv << 4)));
      for (int k = 0; k < 6; k++) begin
        w = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'(16'hA5C3 ^ (k * 16'h1357));
        s = {w[7:0], ~w[15:8]} ^ 16'(dv * 16'h0911);
        if (k == 2) begin
          int n;
          slave_word = s; base = fall_cnt;
          wr(3'd0, w);
          @(posedge sclk);
          n = 0;
          do begin @(posedge clk); #1 n++; end while (sclk);
          check($sformatf("R2 high phase div=%0d", dv), n, dv + 1);
          n = 0;
          do begin @(posedge clk); #1 n++; end while (!sclk);
          check($sformatf("R2 low phase div=%0d", dv), n, dv + 1);
          wait_idle();
        end else begin
          xfer(w, s);
        end
        check("R1 slave saw word", slave_rx, w);
        rd(3'd3, d); check("R3 full set", d[1], 1);
        rd(3'd1, d); check("R1 received word", d, s);
        rd(3'd3, d); check("R3 full cleared by read", d[1], 0);
        check("R1 sclk idle low", sclk, 0);
      end
    end

    // R6 request lines
    wr(3'd4, 16'h0002); wr(3'd5, 16'h0001);
    #1 check("R6 tx-empty request only", dma_req, 2'b10);
    xfer(16'h1234, 16'h4321);
    #1 check("R6 both requests", dma_req, 2'b11);
    rd(3'd1, d);
    #1 check("R6 rx request dropped by read", dma_req, 2'b10);
    wr(3'd4, 16'h0000);
    #1 check("R6 tx request disabled", dma_req, 2'b00);
    xfer(16'h0F0F, 16'hF00F);
    #1 check("R6 rx request level", dma_req, 2'b01);
    repeat (10) @(negedge clk);
    check("R6 rx request held", dma_req, 2'b01);
    rd(3'd1, d);
    wr(3'd5, 16'h0000);

    // R7 write while full is ignored
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'hBEEF);
    wr(3'd0, 16'hDEAD);
    r0 = rises;
    slave_word = 16'h5A5A; base = fall_cnt;
    wr(3'd2, 16'h0001);
    wait_idle();
    check("R7 first word kept", slave_rx, 16'hBEEF);
    check("R7 one transfer only", rises - r0, 16);
    rd(3'd1, d);

    // R8 overrun
    xfer(16'h1111, 16'hC001);
    xfer(16'h2222, 16'hC002);
    rd(3'd3, d); check("R8 overrun set", d[2], 1);
    rd(3'd1, d); check("R8 old word kept", d, 16'hC001);
    wr(3'd3, 16'h0004);
    rd(3'd3, d); check("R8 overrun cleared", d[2], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule